// File: doc/BRIEF.md
# Bundle Instruction Dispersal Unit

The unit looks at a window of six instruction slots, made of two bundles of three, and hands them in program order to a fixed pool of typed issue ports: two integer, two memory, two floating point and three branch. Each slot carries a valid bit, a two-bit unit-type code and a stop marker placed by the compiler. Dispersal walks the slots from the oldest one not yet consumed. It stops at the first slot that finds every port of its type already taken this cycle, or just after a slot whose stop marker closes the instruction group.

Slots that are not issued stay in place and are retried on the next cycle. The unit remembers how far into the older bundle it has already got. Every cycle it reports two values to the fetch side: how many slots were consumed, and how many whole bundles can now be dropped from the window. The fetch side shifts the window by exactly that many bundles. A flush input, raised for a taken branch, empties the window. Nothing issues in that cycle.

Top module: `bundle_disperse`

## Requirements
- R1: Unit-type codes are 0 integer, 1 memory, 2 floating point and 3 branch. Ports 0-1 are integer, 2-3 memory, 4-5 floating point and 6-8 branch. The k-th instruction of a type issued in a cycle, counted in program order, goes to that type's k-th port, so ports of a type fill from the lowest index. Each used port carries the window position of its instruction on `port_pos[3p+:3]`, where position = bundle*3 + slot and bundle 0 is the older one.
- R2: In one cycle no more instructions of a type issue than that type has ports. A valid instruction that finds all ports of its type taken does not issue.
- R3: Issue is strictly in program order. Once a slot stalls, no younger slot issues or is consumed in that cycle, even if a port of its type is free. The stalled slot is retried on the next cycle.
- R4: A slot whose stop bit is set ends dispersal for the cycle once it has been consumed. The next slot waits for the following cycle.
- R5: A slot whose valid bit is clear takes no port, but it is counted as consumed.
- R6: `used` (0 to 6) counts the slots consumed this cycle, starting from the first unconsumed slot. `shift` (0 to 2) is the number of bundles that are now fully consumed. When the older bundle was partly consumed, positions before the carried-over point are skipped on the next cycle.
- R7: While `flush` is high, no port is used and `used` and `shift` are 0. On the next cycle dispersal starts at window position 0.
- R8: While `rst_n` is low, no port is used and `used` is 0. After reset, dispersal starts at window position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| flush | input | 1 | taken-branch flush: empty the window |
| slot_vld | input | 6 | per-slot valid bit, bit i = position i |
| slot_stop | input | 6 | per-slot group stop marker |
| slot_type | input | 12 | per-slot unit-type code, bits 2i+1:2i |
| port_vld | output | NP (9) | issue port in use this cycle |
| port_pos | output | 3*NP (27) | window position driven on each port |
| used | output | 3 | slots consumed this cycle |
| shift | output | 2 | whole bundles the fetch side may drop |

## Verification
Port assignments, `used` and `shift` depend only on the current window and on the stored offset. They are therefore due in the same cycle the window is driven. The bench drives the window one time unit after a rising edge and compares the outputs at the following falling edge. The offset carried over from partial consumption shows up only one rising edge later, as skipped positions. A flush cycle must read all zeros, and the cycle after it must start at position 0. The scoreboard's model advances its own offset and bundle head at each edge, so every expected entry is popped in the cycle its result is due.

// File: rtl/bundle_disperse.sv
module bundle_disperse #(
  parameter int NINT = 2,
  parameter int NMEM = 2,
  parameter int NFP  = 2,
  parameter int NBR  = 3,
  localparam int NP  = NINT + NMEM + NFP + NBR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [5:0]      slot_vld,
  input  logic [5:0]      slot_stop,
  input  logic [11:0]     slot_type,
  output logic [NP-1:0]   port_vld,
  output logic [3*NP-1:0] port_pos,
  output logic [2:0]      used,
  output logic [1:0]      shift
);
  localparam int SLOTS = 6;
  localparam int BSZ   = 3;

  logic [1:0] off_q;
  logic [1:0] nxt_off;
  logic [3:0] sum;

  function automatic int cap(input logic [1:0] t);
    case (t)
      2'd0: return NINT;
      2'd1: return NMEM;
      2'd2: return NFP;
      default: return NBR;
    endcase
  endfunction

  function automatic int base(input logic [1:0] t);
    case (t)
      2'd0: return 0;
      2'd1: return NINT;
      2'd2: return NINT + NMEM;
      default: return NINT + NMEM + NFP;
    endcase
  endfunction

  always_comb begin
    int cnt [4];
    int u;
    int p;
    logic go;
    logic [1:0] t;
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    port_vld = '0;
    port_pos = '0;
    u  = 0;
    p  = 0;
    t  = 2'd0;
    go = rst_n && !flush;
    for (int i = 0; i < SLOTS; i++) begin
      if (go && i >= int'(off_q)) begin
        t = slot_type[2*i +: 2];
        if (!slot_vld[i]) begin
          u = u + 1;
          if (slot_stop[i]) go = 1'b0;
        end else if (cnt[t] < cap(t)) begin
          p = base(t) + cnt[t];
          port_vld[p] = 1'b1;
          port_pos[3*p +: 3] = 3'(i);
          cnt[t] = cnt[t] + 1;
          u = u + 1;
          if (slot_stop[i]) go = 1'b0;
        end else begin
          go = 1'b0;
        end
      end
    end
    used = 3'(u);
  end

  assign sum     = {2'b00, off_q} + {1'b0, used};
  assign shift   = (sum >= 4'(2*BSZ)) ? 2'd2 : (sum >= 4'(BSZ)) ? 2'd1 : 2'd0;
  assign nxt_off = (sum >= 4'(2*BSZ)) ? 2'(sum - 4'(2*BSZ)) :
                   (sum >= 4'(BSZ))   ? 2'(sum - 4'(BSZ))   : sum[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) off_q <= 2'd0;
    else                 off_q <= nxt_off;
  end
endmodule

// File: rtl/bundle_disperse_chk.sv
module bundle_disperse_chk #(
  parameter int NINT = 2,
  parameter int NMEM = 2,
  parameter int NFP  = 2,
  parameter int NBR  = 3,
  localparam int NP  = NINT + NMEM + NFP + NBR
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic [NP-1:0]   port_vld,
  input logic [3*NP-1:0] port_pos,
  input logic [2:0]      used,
  input logic [1:0]      shift
);
  function automatic int ptype(input int j);
    if (j < NINT) return 0;
    if (j < NINT + NMEM) return 1;
    if (j < NINT + NMEM + NFP) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      for (int j = 1; j < NP; j++) begin
        if (ptype(j) == ptype(j-1)) begin
          AST_FILL_LOW: assert (!port_vld[j] || port_vld[j-1]); // R1
          AST_POS_ORDER: assert (!(port_vld[j] && port_vld[j-1]) ||
                                 (port_pos[3*j +: 3] > port_pos[3*(j-1) +: 3])); // R1
        end
      end
    end else begin
      AST_RESET_QUIET: assert (port_vld == '0 && used == 3'd0); // R8
    end
  end

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (port_vld == '0 && used == 3'd0 && shift == 2'd0)); // R7
  AST_ISSUE_LE_USED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_vld) <= int'(used)); // R5
  AST_USED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    used <= 3'd6); // R6
  AST_SHIFT_NEEDS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == 2'd2) |-> (used >= 3'd4)); // R6
endmodule

bind bundle_disperse bundle_disperse_chk #(
  .NINT(NINT), .NMEM(NMEM), .NFP(NFP), .NBR(NBR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .port_vld(port_vld),
  .port_pos(port_pos), .used(used), .shift(shift)
);

// File: tb/test_bundle_disperse.sv
module test_bundle_disperse;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [5:0]  slot_vld = '0;
  logic [5:0]  slot_stop = '0;
  logic [11:0] slot_type = '0;
  logic [8:0]  port_vld;
  logic [26:0] port_pos;
  logic [2:0]  used;
  logic [1:0]  shift;

  bundle_disperse i_bundle_disperse (
    .clk(clk), .rst_n(rst_n), .flush(flush), .slot_vld(slot_vld),
    .slot_stop(slot_stop), .slot_type(slot_type), .port_vld(port_vld),
    .port_pos(port_pos), .used(used), .shift(shift)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [8:0]  v;
    logic [26:0] p;
    logic [2:0]  u;
    logic [1:0]  s;
    string       tag;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [3:0] prog [0:47];
  int plen = 0;
  int head = 0;
  int moff = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(port_vld == e.v, e.tag, "port_vld", 32'(port_vld), 32'(e.v));
      check(port_pos == e.p, "R1", "port_pos", 32'(port_pos), 32'(e.p));
      check(used == e.u, "R6", "used", 32'(used), 32'(e.u));
      check(shift == e.s, "R6", "shift", 32'(shift), 32'(e.s));
    end
  end

  task automatic load(input string s);
    plen = s.len();
    for (int k = 0; k < plen; k++) begin
      case (s[k])
        "I": prog[k] = 4'b1000;  "i": prog[k] = 4'b1100;
        "M": prog[k] = 4'b1001;  "m": prog[k] = 4'b1101;
        "F": prog[k] = 4'b1010;  "f": prog[k] = 4'b1110;
        "B": prog[k] = 4'b1011;  "b": prog[k] = 4'b1111;
        ",": prog[k] = 4'b0100;
        default: prog[k] = 4'b0000;
      endcase
    end
  endtask

  task automatic step(input string tag);
    exp_t e;
    int cnt [4];
    int caps [4];
    int bases [4];
    int u;
    int sum;
    int pn;
    bit go;
    logic [3:0] w [6];
    caps  = '{2, 2, 2, 3};
    bases = '{0, 2, 4, 6};
    for (int i = 0; i < 6; i++) begin
      w[i] = (head*3 + i < plen) ? prog[head*3 + i] : 4'b0000;
      slot_vld[i]  = w[i][3];
      slot_stop[i] = w[i][2];
      slot_type[2*i +: 2] = w[i][1:0];
    end
    flush = 1'b0;
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    e.v = '0; e.p = '0; u = 0; go = 1;
    for (int i = 0; i < 6; i++) begin
      if (go && i >= moff) begin
        if (!w[i][3]) begin
          u++;
          if (w[i][2]) go = 0;
        end else if (cnt[w[i][1:0]] < caps[w[i][1:0]]) begin
          pn = bases[w[i][1:0]] + cnt[w[i][1:0]];
          e.v[pn] = 1'b1;
          e.p[3*pn +: 3] = 3'(i);
          cnt[w[i][1:0]]++;
          u++;
          if (w[i][2]) go = 0;
        end else begin
          go = 0;
        end
      end
    end
    sum = moff + u;
    e.u = 3'(u);
    e.s = 2'(sum / 3);
    e.tag = tag;
    q.push_back(e);
    moff = sum % 3;
    head = head + sum / 3;
    @(posedge clk); #1;
  endtask

  task automatic flush_to(input int target);
    exp_t e;
    flush = 1'b1;
    e.v = '0; e.p = '0; e.u = '0; e.s = '0; e.tag = "R7";
    q.push_back(e);
    moff = 0;
    head = target;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic run(input string tag);
    int guard = 0;
    while (head*3 < plen && guard < 100) begin
      step(tag);
      guard++;
    end
  endtask

  initial begin
    slot_vld = 6'h3f;
    slot_type = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(port_vld == '0 && used == 3'd0, "R8", "reset quiet",
          32'({port_vld, used}), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R2, R3: third integer stalls, younger held, offset carries over (R6)
    load("IIIMFBBBBBMMFFFIMBBBBIIF");
    head = 0; moff = 0;
    run("R3");

    // R4: compiler stops cut dispersal
    load("iMFBiMMMmFFfBbBIIIbMF");
    head = 0; moff = 0;
    run("R4");

    // R5: empty slots consumed without ports
    load("I.M...F.BI..,IMBBBB.....");
    head = 0; moff = 0;
    run("R5");

    // R2: type budget reached exactly, then exceeded
    load("BBBMMFFFFIIIBBBBMMMM");
    head = 0; moff = 0;
    run("R2");

    // R7: flush mid-stream, restart at position 0
    load("IIIMMMFFFBBBIMFBIM");
    head = 0; moff = 0;
    step("R3");
    flush_to(2);
    run("R7");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule